// File: doc/BRIEF.md
# Graphics Command Packet Framer

This block sits at the front of a graphics command processor. It takes a stream of 32-bit command words on a valid/ready input and groups them into complete command packets. The top byte of the first word of each packet is the opcode. A decoder driven by that opcode gives the number of parameter words that follow. The framer writes the header and its parameters into a twelve-slot packet buffer. When the last word is in, it raises a dispatch valid toward the command executor. With that valid it presents the opcode, the total word count and the whole buffer.

An abort input drops a packet that is only partly collected, so the next accepted word starts a new packet. A bypass input belongs to the transfer logic upstream, which decides when the stream is carrying raw image data. While bypass is high, each input word goes straight to a pass-through port and the framer's collection state is left as it was. The executor can hold a dispatch by keeping its ready low. While it does, the framer stops accepting command words.

Top module: `gfx_pkt_framer`

## Requirements
- R1: On a dispatch, `disp_opcode` equals bits 31:24 of the packet's first (header) word.
- R2: Parameter-word counts: opcode 0x02 takes 2; opcodes 0x20..0x23 take 3, 0x24..0x27 take 6, 0x28..0x2B take 4, 0x2C..0x2F take 8.
- R3: Parameter-word counts: opcodes 0x30..0x33 take 5, 0x34..0x37 take 8, 0x38..0x3B take 7, 0x3C..0x3F take 11.
- R4: Parameter-word counts: opcodes 0x40..0x43, 0xA0 and 0xC0 take 2, opcode 0x80 takes 3, and every other opcode takes 0. `disp_len` reports 1 plus the parameter count.
- R5: In `disp_words`, slot k occupies bits [32k+31:32k]. Slot 0 holds the header and slot k holds the k-th accepted parameter word. Slots at index `disp_len` and above read zero.
- R6: `disp_valid` rises in the cycle after the edge that accepts a packet's last word. A header with zero parameters counts as its own last word.
- R7: While `disp_valid` is high and `disp_ready` is low, the dispatch outputs hold their values, and `in_ready` is low unless bypass is high. A dispatch is consumed at an edge where `disp_ready` is high.
- R8: An abort cycle accepts no command word (`in_ready` low unless bypass) and discards any partial packet, so the next accepted word is a header. A pending dispatch is not cancelled by an abort.
- R9: While `bypass_i` is high, `in_ready` is high, `pass_valid` equals `in_valid`, and `pass_data` equals `in_data` in the same cycle. The words are not collected, and a packet that was partly collected continues afterwards.
- R10: After reset, `disp_valid` and `pass_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input command word |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| bypass_i | input | 1 | Route input words to the pass-through port |
| abort_i | input | 1 | Discard the partial packet |
| pass_valid | output | 1 | Pass-through word valid |
| pass_data | output | 32 | Pass-through word |
| disp_ready | input | 1 | Executor accepts the dispatch |
| disp_valid | output | 1 | A complete packet is presented |
| disp_opcode | output | 8 | Opcode of the presented packet |
| disp_len | output | 4 | Words in the packet, header included (1..12) |
| disp_words | output | 384 | Packet buffer, slot k at bits [32k+31:32k] |

## Verification
The ready and pass-through outputs are combinational. They are compared with the reference model 1 ns after the inputs change, inside the same cycle. Dispatch results have one register in their path. They are compared at the falling edge that follows the accepting rising edge, so a zero-parameter header is seen as dispatched half a cycle after its accepting edge. A behavioural queue model steps once per rising edge. It sweeps all 256 opcodes and also runs with random executor stalls, aborts partway through a packet and bypass bursts partway through a packet.

// File: rtl/gfx_pkt_pkg.sv
package gfx_pkt_pkg;

   localparam int unsigned OPC_BITS  = 8;
   localparam int unsigned MAX_EXTRA = 11;
   localparam int unsigned EXTRA_W   = $clog2(MAX_EXTRA + 1);

   typedef logic [OPC_BITS-1:0] opc_t;
   typedef logic [EXTRA_W-1:0]  extra_t;

   // Parameter-word count per opcode. The 0x20..0x3F primitive range is
   // decoded by its group of four opcodes.
   function automatic extra_t extra_for(input opc_t op);
      extra_t n;
      n = '0;
      if (op[7:5] == 3'b001) begin
         unique case (op[4:2])
            3'd0: n = extra_t'(3);
            3'd1: n = extra_t'(6);
            3'd2: n = extra_t'(4);
            3'd3: n = extra_t'(8);
            3'd4: n = extra_t'(5);
            3'd5: n = extra_t'(8);
            3'd6: n = extra_t'(7);
            default: n = extra_t'(11);
         endcase
      end else if (op == 8'h80) begin
         n = extra_t'(3);
      end else if (op == 8'h02 || op == 8'hA0 || op == 8'hC0 || op[7:2] == 6'b010000) begin
         n = extra_t'(2);
      end
      return n;
   endfunction

endpackage

// File: rtl/gfx_pkt_len_lut.sv
module gfx_pkt_len_lut
   import gfx_pkt_pkg::*;
#(
   parameter bit REG_FREE = 1'b1
) (
   input  opc_t   opcode,
   output extra_t extra
);

   generate
      if (REG_FREE) begin : g_decode
         assign extra = extra_for(opcode);
      end else begin : g_table
         extra_t tbl [2**OPC_BITS];
         always_comb begin
            for (int i = 0; i < 2**OPC_BITS; i++) begin
               tbl[i] = extra_for(opc_t'(i));
            end
         end
         assign extra = tbl[opcode];
      end
   endgenerate

   always_comb begin
      a_r4_extra_bound : assert (extra <= extra_t'(MAX_EXTRA))
         else $error("parameter count above maximum");
   end

endmodule

// File: rtl/gfx_pkt_seq.sv
module gfx_pkt_seq
   import gfx_pkt_pkg::*;
#(
   parameter int unsigned BUF_WORDS = 12,
   localparam int unsigned IDX_W    = $clog2(BUF_WORDS),
   localparam int unsigned LEN_W    = $clog2(BUF_WORDS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             word_acc,
   input  logic             abort_i,
   input  logic             disp_ready,
   input  extra_t           hdr_extra,
   output logic             hdr_phase,
   output logic [IDX_W-1:0] wr_idx,
   output logic             disp_valid,
   output logic [LEN_W-1:0] disp_len
);

   extra_t           rem_q;
   logic [IDX_W-1:0] idx_q;
   logic [LEN_W-1:0] total_q;
   logic [LEN_W-1:0] len_q;
   logic             dv_q;
   logic             pkt_done;
   logic [LEN_W-1:0] hdr_total;

   assign hdr_phase = (rem_q == '0);
   assign wr_idx    = hdr_phase ? '0 : idx_q;
   assign hdr_total = LEN_W'(hdr_extra) + LEN_W'(1);
   assign pkt_done  = word_acc && (hdr_phase ? (hdr_extra == '0) : (rem_q == extra_t'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q   <= '0;
         idx_q   <= '0;
         total_q <= '0;
      end else if (abort_i) begin
         rem_q   <= '0;
         idx_q   <= '0;
      end else if (word_acc) begin
         if (hdr_phase) begin
            rem_q   <= hdr_extra;
            idx_q   <= IDX_W'(1);
            total_q <= hdr_total;
         end else begin
            rem_q   <= rem_q - extra_t'(1);
            idx_q   <= idx_q + IDX_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q  <= 1'b0;
         len_q <= '0;
      end else if (pkt_done) begin
         dv_q  <= 1'b1;
         len_q <= hdr_phase ? hdr_total : total_q;
      end else if (disp_ready) begin
         dv_q  <= 1'b0;
      end
   end

   assign disp_valid = dv_q;
   assign disp_len   = len_q;

   a_r8_abort_clears : assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (rem_q == '0))
      else $error("abort left a partial packet");

   a_r6_rem_bound : assert property (@(posedge clk) disable iff (!rst_n)
      rem_q <= extra_t'(MAX_EXTRA))
      else $error("remaining count out of range");

   a_r7_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (dv_q && !disp_ready) |=> (dv_q && $stable(len_q)))
      else $error("dispatch dropped while stalled");

   a_r5_len_range : assert property (@(posedge clk) disable iff (!rst_n)
      dv_q |-> (len_q >= LEN_W'(1) && len_q <= LEN_W'(BUF_WORDS)))
      else $error("dispatch length out of range");

endmodule

// File: rtl/gfx_pkt_buf.sv
module gfx_pkt_buf #(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned BUF_WORDS    = 12,
   parameter bit          CLEAR_UNUSED = 1'b1,
   localparam int unsigned IDX_W       = $clog2(BUF_WORDS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic                        hdr_wr,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [DATA_W-1:0]           wr_data,
   output logic [BUF_WORDS*DATA_W-1:0] words
);

   generate
      for (genvar g = 0; g < BUF_WORDS; g++) begin : g_slot
         logic [DATA_W-1:0] slot_q;
         logic              hit;
         assign hit = wr_en && (wr_idx == IDX_W'(g));

         if (CLEAR_UNUSED && g != 0) begin : g_clr
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                slot_q <= '0;
               else if (hit)              slot_q <= wr_data;
               else if (wr_en && hdr_wr)  slot_q <= '0;
            end
         end else begin : g_keep
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   slot_q <= '0;
               else if (hit) slot_q <= wr_data;
            end
         end

         assign words[g*DATA_W +: DATA_W] = slot_q;
      end
   endgenerate

   a_r5_hdr_slot0 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hdr_wr) |-> (wr_idx == '0))
      else $error("header written outside slot 0");

endmodule

// File: rtl/gfx_pkt_bypass.sv
module gfx_pkt_bypass #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              bypass_i,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              pass_valid,
   output logic [DATA_W-1:0] pass_data,
   output logic              cmd_valid
);

   assign pass_valid = in_valid && bypass_i;
   assign pass_data  = in_data;
   assign cmd_valid  = in_valid && !bypass_i;

endmodule

// File: rtl/gfx_pkt_framer.sv
module gfx_pkt_framer
   import gfx_pkt_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned BUF_WORDS    = 12,
   parameter bit          CLEAR_UNUSED = 1'b1,
   parameter bit          DECODE_LEN   = 1'b1,
   localparam int unsigned IDX_W       = $clog2(BUF_WORDS),
   localparam int unsigned LEN_W       = $clog2(BUF_WORDS + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [DATA_W-1:0]           in_data,
   output logic                        in_ready,
   input  logic                        bypass_i,
   input  logic                        abort_i,
   output logic                        pass_valid,
   output logic [DATA_W-1:0]           pass_data,
   input  logic                        disp_ready,
   output logic                        disp_valid,
   output logic [OPC_BITS-1:0]         disp_opcode,
   output logic [LEN_W-1:0]            disp_len,
   output logic [BUF_WORDS*DATA_W-1:0] disp_words
);

   generate
      if (BUF_WORDS < MAX_EXTRA + 1) begin : g_chk_depth
         $error("BUF_WORDS must hold the longest packet");
      end
      if (DATA_W < OPC_BITS) begin : g_chk_width
         $error("DATA_W must hold the opcode field");
      end
   endgenerate

   logic             cmd_valid;
   logic             word_acc;
   logic             hdr_phase;
   logic [IDX_W-1:0] wr_idx;
   extra_t           hdr_extra;
   logic             cmd_room;

   gfx_pkt_bypass #(.DATA_W(DATA_W)) u_bypass (
      .bypass_i  (bypass_i),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .pass_valid(pass_valid),
      .pass_data (pass_data),
      .cmd_valid (cmd_valid)
   );

   gfx_pkt_len_lut #(.REG_FREE(DECODE_LEN)) u_lut (
      .opcode(in_data[DATA_W-1 -: OPC_BITS]),
      .extra (hdr_extra)
   );

   assign cmd_room = !abort_i && (!disp_valid || disp_ready);
   assign in_ready = bypass_i || cmd_room;
   assign word_acc = cmd_valid && cmd_room;

   gfx_pkt_seq #(.BUF_WORDS(BUF_WORDS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_acc  (word_acc),
      .abort_i   (abort_i),
      .disp_ready(disp_ready),
      .hdr_extra (hdr_extra),
      .hdr_phase (hdr_phase),
      .wr_idx    (wr_idx),
      .disp_valid(disp_valid),
      .disp_len  (disp_len)
   );

   gfx_pkt_buf #(
      .DATA_W      (DATA_W),
      .BUF_WORDS   (BUF_WORDS),
      .CLEAR_UNUSED(CLEAR_UNUSED)
   ) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (word_acc),
      .hdr_wr (hdr_phase),
      .wr_idx (wr_idx),
      .wr_data(in_data),
      .words  (disp_words)
   );

   assign disp_opcode = disp_words[DATA_W-1 -: OPC_BITS];

   a_r7_stall_blocks : assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !disp_ready && !bypass_i) |-> !in_ready)
      else $error("input accepted while dispatch stalled");

   a_r7_words_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !disp_ready) |=> $stable(disp_words))
      else $error("dispatch words changed while stalled");

   a_r9_pass_ready : assert property (@(posedge clk) disable iff (!rst_n)
      bypass_i |-> (in_ready && pass_valid == in_valid))
      else $error("bypass word not passed");

   a_r9_no_dispatch : assert property (@(posedge clk) disable iff (!rst_n)
      (bypass_i && !disp_valid) |=> !disp_valid)
      else $error("bypass word completed a packet");

endmodule

// File: tb/gfx_pkt_framer_tb_top.sv
`timescale 1ns/1ps
module gfx_pkt_framer_tb_top;

   localparam int NW = 12;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [31:0]    in_data = '0;
   logic           in_ready;
   logic           bypass_i = 1'b0;
   logic           abort_i = 1'b0;
   logic           pass_valid;
   logic [31:0]    pass_data;
   logic           disp_ready = 1'b1;
   logic           disp_valid;
   logic [7:0]     disp_opcode;
   logic [3:0]     disp_len;
   logic [NW*32-1:0] disp_words;

   always #2.5 clk = ~clk;

   gfx_pkt_framer dut_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .bypass_i(bypass_i), .abort_i(abort_i),
      .pass_valid(pass_valid), .pass_data(pass_data),
      .disp_ready(disp_ready), .disp_valid(disp_valid),
      .disp_opcode(disp_opcode), .disp_len(disp_len), .disp_words(disp_words)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   // reference model state
   int unsigned mq[$];
   int          m_need = 0;
   bit          m_dv = 0;
   int          m_len = 0;
   int          m_op = 0;
   int unsigned m_words[NW];
   bit          m_acc = 0;
   bit          stall_mode = 0;

   function automatic int ref_extra(int op);
      int grp[8] = '{3, 6, 4, 8, 5, 8, 7, 11};
      if (op >= 'h20 && op <= 'h3F) return grp[(op - 'h20) / 4];
      if (op == 'h80) return 3;
      if (op == 'h02 || op == 'hA0 || op == 'hC0) return 2;
      if (op >= 'h40 && op <= 'h43) return 2;
      return 0;
   endfunction

   function automatic string len_tag(int op);
      if (op >= 'h30 && op <= 'h3F) return "R3";
      if (op == 'h02 || (op >= 'h20 && op <= 'h2F)) return "R2";
      return "R4";
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: drive at the falling edge, check combinational outputs,
   // step the model at the rising edge, check registered outputs after it.
   task automatic cyc(input bit v, input logic [31:0] d, input bit byp, input bit ab, input bit dr);
      bit rdy;
      bit acc;
      in_valid = v; in_data = d; bypass_i = byp; abort_i = ab; disp_ready = dr;
      #1;
      rdy = byp ? 1'b1 : (!ab && (!m_dv || dr));
      chk(in_ready === rdy, byp ? "R9" : (ab ? "R8" : "R7"), in_ready, rdy);
      chk(pass_valid === (v && byp), "R9", pass_valid, v && byp);
      if (v && byp) chk(pass_data === d, "R9", pass_data, d);
      @(posedge clk);
      acc = v && rdy && !byp;
      if (ab) mq.delete();
      if (m_dv && dr) m_dv = 0;
      if (acc) begin
         mq.push_back(d);
         if (mq.size() == 1) m_need = ref_extra(int'(d[31:24]));
         if (mq.size() == m_need + 1) begin
            m_dv = 1;
            m_len = mq.size();
            m_op = int'(mq[0] >> 24);
            for (int i = 0; i < NW; i++) m_words[i] = (i < mq.size()) ? mq[i] : 0;
            mq.delete();
         end
      end
      m_acc = acc;
      @(negedge clk);
      chk(disp_valid === m_dv, "R6", disp_valid, m_dv);
      if (m_dv && disp_valid) begin
         chk(disp_opcode === m_op[7:0], "R1", disp_opcode, m_op);
         chk(disp_len === m_len[3:0], len_tag(m_op), disp_len, m_len);
         for (int i = 0; i < NW; i++)
            chk(disp_words[i*32 +: 32] === m_words[i], "R5", disp_words[i*32 +: 32], m_words[i]);
      end
   endtask

   function automatic bit pick_ready();
      return stall_mode ? bit'($urandom % 2) : 1'b1;
   endfunction

   task automatic send(input logic [31:0] d);
      for (int t = 0; t < 64; t++) begin
         cyc(1'b1, d, 1'b0, 1'b0, pick_ready());
         if (m_acc) break;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, 1'b0, pick_ready());
   endtask

   task automatic packet(input int op, input int seed);
      send({op[7:0], seed[23:0]});
      for (int k = 1; k <= ref_extra(op); k++) begin
         if (stall_mode && ($urandom % 3 == 0)) idle(1);
         send(32'hA500_0000 + (seed << 4) + k);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      // R10 reset state
      chk(disp_valid === 1'b0, "R10", disp_valid, 0);
      chk(in_ready === 1'b1, "R10", in_ready, 1);
      chk(pass_valid === 1'b0, "R10", pass_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1..R5: every opcode, executor always ready
      for (int op = 0; op < 256; op++) packet(op, op * 7 + 3);
      idle(2);

      // R6: back-to-back zero-parameter headers dispatch one per cycle
      for (int i = 0; i < 4; i++) begin
         cyc(1'b1, {8'h00, 24'h000100 + 24'(i)}, 1'b0, 1'b0, 1'b1);
         chk(disp_valid === 1'b1 && disp_len === 4'd1, "R6", {disp_valid, disp_len}, 5'h11);
      end
      idle(1);

      // R7: random executor stalls and input gaps
      stall_mode = 1;
      for (int r = 0; r < 120; r++) packet(int'($urandom % 256), r);
      stall_mode = 0;
      idle(3);

      // R8: abort partway through an 11-parameter packet
      send(32'h3C00_0001);
      for (int k = 0; k < 4; k++) send(32'h1111_0000 + k);
      cyc(1'b1, 32'h2222_2222, 1'b0, 1'b1, 1'b1);
      send(32'h0000_00AA);
      chk(disp_valid === 1'b1 && disp_len === 4'd1, "R8", disp_len, 1);
      chk(disp_words[63:32] === 32'h0, "R8", disp_words[63:32], 0);
      idle(1);

      // R8: abort does not cancel a pending dispatch
      send(32'h0200_0005);
      send(32'h0000_0001);
      cyc(1'b1, 32'h0000_0002, 1'b0, 1'b0, 1'b0);
      cyc(1'b0, '0, 1'b0, 1'b1, 1'b0);
      chk(disp_valid === 1'b1 && disp_opcode === 8'h02, "R8", disp_opcode, 2);
      cyc(1'b0, '0, 1'b0, 1'b0, 1'b0);
      idle(2);

      // R9: bypass burst inside a 4-parameter packet
      send(32'h2800_0777);
      send(32'hB000_0001);
      send(32'hB000_0002);
      for (int i = 0; i < 3; i++) cyc(1'b1, 32'hDEAD_0000 + i, 1'b1, 1'b0, 1'b1);
      chk(disp_valid === 1'b0, "R9", disp_valid, 0);
      send(32'hB000_0003);
      send(32'hB000_0004);
      chk(disp_valid === 1'b1 && disp_words[95:64] === 32'hB000_0002, "R9", disp_words[95:64], 32'hB000_0002);
      chk(disp_len === 4'd5, "R4", disp_len, 5);
      idle(2);

      // R9: bypass while a dispatch is stalled still passes words
      send(32'h0000_0000);
      cyc(1'b1, 32'hCAFE_0001, 1'b1, 1'b0, 1'b0);
      cyc(1'b1, 32'hCAFE_0002, 1'b1, 1'b0, 1'b0);
      idle(2);

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule